// File: doc/BRIEF.md
# Jack-Sense Output Enable Gating

This block watches one of several general-purpose input pins as a headphone or accessory sense line and uses its settled level to decide which output drivers may be on. The chosen pin passes through a synchronizer and a debouncer. The settled level then picks one of two per-output enable masks, which are ANDed into the normal driver enables. It also picks one of two reference-driver bits, which is ORed into the normal reference-driver enable.

All configuration arrives as plain input ports from a register file elsewhere: the pin select, a detection on/off bit, the two output masks, a two-bit reference mask and the normal enables. When detection is off, the output masks are treated as all ones and the reference bit as zero, so the normal enables pass through. The final enables are registered. Analog drivers, pad logic and the register bus are outside this block.

Top module: `jsense_enable_gate`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `drv_en_o` and `ref_en_o` are 0, and the settled sense level starts at 0.
- R2: `sense_sel_i` value k (0 to 3) selects bit k of `gpio_i` as the sense input (value 0 is the first pin, value 3 the fourth).
- R3: A new sense level is adopted only once the synchronized selected pin has kept one value for `DEBOUNCE_CYCLES` further clock edges after the edge that first saw it; any shorter pulse leaves the outputs unchanged.
- R4: With detection on, a settled level of 0 uses `lvl0_mask_i` and a level of 1 uses `lvl1_mask_i`; bit i of the chosen mask governs output i.
- R5: Each bit of `drv_en_o` is the normal enable bit ANDed with the chosen mask bit, so a normally disabled output stays off whatever the mask holds.
- R6: `ref_en_o` is `ref_en_i` ORed with `ref_mask_i[0]` when the level is 0 or `ref_mask_i[1]` when the level is 1.
- R7: With detection off, `drv_en_o` follows `drv_en_i` and `ref_en_o` follows `ref_en_i` unchanged.
- R8: A change of `sense_sel_i`, or a rise of `detect_en_i`, restarts the debounce count; the previous settled level is held until the newly selected pin has been stable for a full interval.
- R9: Outputs are registered: a change on any enable, mask or detection input shows at the outputs one clock later.
- R10: The raw pin level is used as-is with no inversion: a high pin gives level 1 and selects `lvl1_mask_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_i | input | NUM_PINS | Raw general-purpose pin levels |
| sense_sel_i | input | SEL_W | Index of the pin used as sense input |
| detect_en_i | input | 1 | Detection on (1) or off (0) |
| lvl0_mask_i | input | NUM_OUTS | Output mask used at sense level 0 |
| lvl1_mask_i | input | NUM_OUTS | Output mask used at sense level 1 |
| ref_mask_i | input | 2 | Reference bit per level: bit 0 for level 0, bit 1 for level 1 |
| drv_en_i | input | NUM_OUTS | Normal per-output driver enables |
| ref_en_i | input | 1 | Normal reference-driver enable |
| drv_en_o | output | NUM_OUTS | Final per-output driver enables |
| ref_en_o | output | 1 | Final reference-driver enable |

## Verification
On every cycle the assertions check that no output is on unless its normal enable was on, that the reference output is on whenever the normal reference enable was, that detection off gives pure pass-through, that the settled level only moves after a full count, and that a reselect or detection rise clears the count and holds the level. Which mask is picked for which level and pin, the exact settle delay, glitch rejection and the hold across a pin change need whole input sequences, so only the bench scenarios against the cycle model show them.

// File: rtl/jsense_pkg.sv
package jsense_pkg;
   localparam int unsigned JS_DEF_PINS     = 4;
   localparam int unsigned JS_DEF_OUTS     = 4;
   localparam int unsigned JS_DEF_DEBOUNCE = 16;
   localparam int unsigned JS_DEF_SYNC     = 2;
   localparam int unsigned JS_REF_LEVELS   = 2;

   function automatic logic pick_by_level(input logic level, input logic [1:0] pair);
      return level ? pair[1] : pair[0];
   endfunction
endpackage

// File: rtl/jsense_sync.sv
module jsense_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/jsense_debounce.sv
module jsense_debounce #(
   parameter int unsigned NUM_PINS        = 4,
   parameter int unsigned DEBOUNCE_CYCLES = 16,
   localparam int unsigned SEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
   localparam int unsigned CNT_W = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] sync_i,
   input  logic [SEL_W-1:0]    sel_i,
   input  logic                det_en_i,
   output logic                level_o
);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

   logic [SEL_W-1:0] sel_q;
   logic             det_q;
   logic             cand_q;
   logic             level_q;
   logic [CNT_W-1:0] cnt_q;
   logic             cur;
   logic             restart;

   assign cur     = sync_i[sel_i];
   assign restart = (sel_i != sel_q) || (det_en_i && !det_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         det_q   <= 1'b0;
         cand_q  <= 1'b0;
         level_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         sel_q <= sel_i;
         det_q <= det_en_i;
         if (restart || (cur != cand_q)) begin
            cand_q <= cur;
            cnt_q  <= '0;
         end else if (cnt_q != CNT_LAST) begin
            cnt_q <= cnt_q + 1'b1;
         end else begin
            level_q <= cand_q;
         end
      end
   end

   assign level_o = level_q;

   AST_SETTLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(level_q) |-> ($past(cnt_q) == CNT_LAST)); // R3

   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0)); // R8

   AST_RESTART_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> $stable(level_q)); // R8
endmodule

// File: rtl/jsense_gate.sv
module jsense_gate
   import jsense_pkg::*;
#(
   parameter int unsigned NUM_OUTS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                det_en_i,
   input  logic                level_i,
   input  logic [NUM_OUTS-1:0] m0_i,
   input  logic [NUM_OUTS-1:0] m1_i,
   input  logic [1:0]          ref_mask_i,
   input  logic [NUM_OUTS-1:0] drv_en_i,
   input  logic                ref_en_i,
   output logic [NUM_OUTS-1:0] drv_en_o,
   output logic                ref_en_o
);
   logic [NUM_OUTS-1:0] eff_mask;
   logic                eff_ref;
   logic [NUM_OUTS-1:0] drv_q;
   logic                ref_q;
   logic                run_q;

   generate
      for (genvar i = 0; i < NUM_OUTS; i++) begin : g_out
         assign eff_mask[i] = det_en_i ? pick_by_level(level_i, {m1_i[i], m0_i[i]}) : 1'b1;
      end
   endgenerate

   assign eff_ref = det_en_i & pick_by_level(level_i, ref_mask_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_q <= '0;
         ref_q <= 1'b0;
         run_q <= 1'b0;
      end else begin
         drv_q <= drv_en_i & eff_mask;
         ref_q <= ref_en_i | eff_ref;
         run_q <= 1'b1;
      end
   end

   assign drv_en_o = drv_q;
   assign ref_en_o = ref_q;

   AST_OUT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_q & ~$past(drv_en_i)) == '0); // R5

   AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !$past(det_en_i)) |-> ((drv_q == $past(drv_en_i)) && (ref_q == $past(ref_en_i)))); // R7

   AST_REF_OR: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(ref_en_i)) |-> ref_q); // R6
endmodule

// File: rtl/jsense_enable_gate.sv
module jsense_enable_gate
   import jsense_pkg::*;
#(
   parameter int unsigned NUM_PINS        = JS_DEF_PINS,
   parameter int unsigned NUM_OUTS        = JS_DEF_OUTS,
   parameter int unsigned DEBOUNCE_CYCLES = JS_DEF_DEBOUNCE,
   parameter int unsigned SYNC_STAGES     = JS_DEF_SYNC,
   localparam int unsigned SEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] gpio_i,
   input  logic [SEL_W-1:0]    sense_sel_i,
   input  logic                detect_en_i,
   input  logic [NUM_OUTS-1:0] lvl0_mask_i,
   input  logic [NUM_OUTS-1:0] lvl1_mask_i,
   input  logic [1:0]          ref_mask_i,
   input  logic [NUM_OUTS-1:0] drv_en_i,
   input  logic                ref_en_i,
   output logic [NUM_OUTS-1:0] drv_en_o,
   output logic                ref_en_o
);
   generate
      if (NUM_PINS < 2)        begin : g_chk_pins  $error("NUM_PINS must be at least 2");        end
      if (NUM_OUTS < 1)        begin : g_chk_outs  $error("NUM_OUTS must be at least 1");        end
      if (DEBOUNCE_CYCLES < 2) begin : g_chk_deb   $error("DEBOUNCE_CYCLES must be at least 2"); end
      if (SYNC_STAGES < 2)     begin : g_chk_sync  $error("SYNC_STAGES must be at least 2");     end
   endgenerate

   logic [NUM_PINS-1:0] gpio_sync;
   logic                level;

   jsense_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (gpio_i),
      .q_o   (gpio_sync)
   );

   jsense_debounce #(.NUM_PINS(NUM_PINS), .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_i   (gpio_sync),
      .sel_i    (sense_sel_i),
      .det_en_i (detect_en_i),
      .level_o  (level)
   );

   jsense_gate #(.NUM_OUTS(NUM_OUTS)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .det_en_i   (detect_en_i),
      .level_i    (level),
      .m0_i       (lvl0_mask_i),
      .m1_i       (lvl1_mask_i),
      .ref_mask_i (ref_mask_i),
      .drv_en_i   (drv_en_i),
      .ref_en_i   (ref_en_i),
      .drv_en_o   (drv_en_o),
      .ref_en_o   (ref_en_o)
   );
endmodule

// File: tb/jsense_enable_gate_test.sv
module jsense_enable_gate_test;
   localparam int DEB = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] gpio = '0;
   logic [1:0] sel = '0;
   logic       det = 1'b0;
   logic [3:0] l0 = '0, l1 = '0;
   logic [1:0] rmask = '0;
   logic [3:0] nen = '0;
   logic       nref = 1'b0;
   logic [3:0] drv_o;
   logic       ref_o;

   int vectors = 0;
   int errors  = 0;
   string phase = "R1";

   always #5 clk = ~clk;

   jsense_enable_gate #(.DEBOUNCE_CYCLES(DEB)) uut (
      .clk(clk), .rst_n(rst_n), .gpio_i(gpio), .sense_sel_i(sel), .detect_en_i(det),
      .lvl0_mask_i(l0), .lvl1_mask_i(l1), .ref_mask_i(rmask), .drv_en_i(nen),
      .ref_en_i(nref), .drv_en_o(drv_o), .ref_en_o(ref_o)
   );

   // behavioural reference model
   logic [3:0] pin_hist [$];
   int  run_len;
   bit  m_lvl, m_cand, m_detp, m_ref;
   int  m_selp;
   logic [3:0] m_out;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_hist = '{4'h0, 4'h0};
         run_len = 0; m_lvl = 0; m_cand = 0; m_detp = 0; m_selp = 0;
         m_out = '0; m_ref = 0;
      end else begin
         bit cur;
         bit restart;
         if (det) begin
            m_out = nen & (m_lvl ? l1 : l0);
            m_ref = nref | rmask[m_lvl];
         end else begin
            m_out = nen;
            m_ref = nref;
         end
         cur = pin_hist[0][sel];
         restart = (int'(sel) != m_selp) || (det && !m_detp);
         if (restart || cur != m_cand) begin
            m_cand = cur;
            run_len = 0;
         end else if (run_len < DEB - 1) begin
            run_len++;
         end else begin
            m_lvl = m_cand;
         end
         m_selp = int'(sel);
         m_detp = det;
         pin_hist.push_back(gpio);
         void'(pin_hist.pop_front());
      end
   end

   task automatic tick();
      @(negedge clk);
      vectors++;
      if (drv_o !== m_out || ref_o !== m_ref) begin
         errors++;
         $display("FAIL %s: drv_en_o=%b ref_en_o=%b expected drv=%b ref=%b",
                  phase, drv_o, ref_o, m_out, m_ref);
      end
   endtask

   task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic settle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      // R1: reset values
      nen = 4'hF; nref = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", {drv_o, ref_o}, 5'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {drv_o, ref_o}, {4'hF, 1'b1});

      // R7: detection off, pass-through whatever the masks and pins
      phase = "R7/R9";
      l0 = 4'h0; l1 = 4'h0; rmask = 2'b11; gpio = 4'hA;
      for (int n = 0; n < 32; n++) begin
         nen = n[3:0]; nref = n[4];
         tick();
      end

      // R2/R4/R5/R6/R10: every select, level, normal enable and reference mask
      det = 1'b1;
      for (int s = 0; s < 4; s++) begin
         for (int lv = 0; lv < 2; lv++) begin
            phase = "R2/R4/R10";
            sel = s[1:0];
            gpio = lv[0] ? ~(4'b1 << s) : (4'b1 << s);
            gpio = lv[0] ? ~gpio : gpio;
            gpio = lv[0] ? (4'b1 << s) : ~(4'b1 << s);
            l0 = 4'(s * 3 + 5); l1 = ~4'(s * 5 + 2);
            settle(DEB + 6);
            phase = "R5/R6/R9";
            for (int n = 0; n < 128; n++) begin
               nen = n[3:0]; nref = n[4]; rmask = n[6:5];
               tick();
            end
            // explicit: level 1 picks lvl1 mask, level 0 picks lvl0 mask
            nen = 4'hF; nref = 1'b0; rmask = 2'b10;
            tick(); tick();
            chk(lv[0] ? "R10" : "R4", {drv_o, ref_o}, lv[0] ? {l1, 1'b1} : {l0, 1'b0});
         end
      end

      // R3: glitch shorter than the interval leaves the outputs alone
      phase = "R3";
      sel = 2'd2; gpio = 4'h0; l0 = 4'h3; l1 = 4'hC; nen = 4'hF; rmask = 2'b01;
      settle(DEB + 6);
      gpio[2] = 1'b1;
      settle(DEB - 1);
      gpio[2] = 1'b0;
      settle(DEB + 6);
      chk("R3", {drv_o, ref_o}, {4'h3, 1'b1});
      // a pulse long enough does change it
      gpio[2] = 1'b1;
      settle(DEB + 6);
      chk("R3", {drv_o, ref_o}, {4'hC, 1'b0});

      // R8: reselect onto a low pin holds the old level for an interval
      phase = "R8";
      sel = 2'd1;
      settle(DEB - 2);
      chk("R8", {drv_o, ref_o}, {4'hC, 1'b0});
      settle(8);
      chk("R8", {drv_o, ref_o}, {4'h3, 1'b1});

      // R8: detection rise restarts the count
      det = 1'b0; gpio = 4'h2;
      settle(4);
      det = 1'b1;
      settle(DEB + 6);
      gpio = 4'h0;
      settle(DEB + 6);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule